// File: doc/BRIEF.md
# Partitioned Cache Victim Selector

This block picks the way to evict from one set of a set-associative cache when a fill or a line lock is needed. A requester can be one of several cores or one of two hardware-agent groups. Each requester has its own programmable way mask. Set bit w to forbid that requester from evicting way w. Clear bit w to allow it. The masks only limit which way can be chosen as a victim. Hit detection and reads sit outside this block and never look at the masks.

For each request the block receives four bits per way from the addressed set: valid, dirty, locked and a use bit. A candidate way is one that the requester's mask allows and that is not locked. The result is registered and appears one clock after the request strobe. It carries:

- a found flag;
- the chosen way;
- whether a writeback is needed;
- the use bits to clear;
- for lock requests, the way whose lock bit should be set.

The tag array itself is outside this block and applies these updates. Masks are written through a small configuration port. A write that would forbid every way is dropped.

Top module: `way_victim_sel`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. It is low otherwise.
- R2: After reset every mask is zero and every way is allowed for every requester.
- R3: A way whose `set_locked` bit is 1 is never returned as the victim.
- R4: `req_kind` 0 selects core `req_core`. A 1 in bit w of that core's mask forbids way w, and a 0 allows it. Each core's mask is independent of the other cores' masks.
- R5: `req_kind` 1 selects agent group A, and `req_kind` 2 or 3 selects agent group B. Each group has its own mask, separate from the core masks and from the other group's mask.
- R6: A configuration write with every mask bit set is ignored and the previous mask is kept. `cfg_kind` and `cfg_core` use the same encoding as `req_kind` and `req_core`.
- R7: If any candidate way is invalid, the lowest-index invalid candidate is chosen.
- R8: Otherwise the lowest-index candidate whose use bit is 0 is chosen.
- R9: If every candidate has its use bit set, the lowest-index candidate is chosen. `upd_use_clear` then has a 1 for every unlocked way of the set. In every other case `upd_use_clear` is 0.
- R10: `rsp_dirty` is 1 only when the chosen way is both valid and dirty.
- R11: With no candidate, `rsp_found` is 0 and `rsp_way` is 0. `rsp_dirty`, `upd_use_clear` and `upd_lock_set` are all 0.
- R12: For a lock request (`req_lock`=1) that finds a victim, `upd_lock_set` is one-hot on the chosen way. For any other request it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_kind | input | 2 | Mask target class: 0 core, 1 group A, 2/3 group B |
| cfg_core | input | CORE_W | Core index for a core mask write |
| cfg_mask | input | WAYS | New mask, 1 forbids eviction from that way |
| req_valid | input | 1 | Victim request strobe |
| req_lock | input | 1 | Request is a line lock |
| req_kind | input | 2 | Requester class, same encoding as cfg_kind |
| req_core | input | CORE_W | Requesting core index |
| set_valid | input | WAYS | Valid bits of the addressed set |
| set_dirty | input | WAYS | Dirty bits of the addressed set |
| set_locked | input | WAYS | Lock bits of the addressed set |
| set_use | input | WAYS | Use bits of the addressed set |
| rsp_valid | output | 1 | Result valid |
| rsp_found | output | 1 | A victim was found |
| rsp_way | output | WAY_W | Chosen way |
| rsp_dirty | output | 1 | Chosen victim needs writeback |
| upd_use_clear | output | WAYS | Use bits to clear |
| upd_lock_set | output | WAYS | Lock bit to set |

## Verification
The bench targets the ordering of the victim rules.

- An invalid way that is locked must lose to a valid unlocked one. A design that ranks invalid ways before checking locks would pick it.
- When every candidate's use bit is set, the clear vector must spare locked ways. A design that clears every use bit would wipe recency on locked lines.
- A dirty bit on an invalid way must not request a writeback.

The bench also covers the mask paths:

- An all-ones mask write must leave the old partition intact. A design that accepts it would leave the requester with no victim at all.
- A lock request with no free way must leave every update vector at zero.
- The separate masks for each core and each group must not leak into one another. Leakage would show up as the wrong way for a neighbour.

// File: rtl/way_victim_sel_pkg.sv
package way_victim_sel_pkg;

   // requester class encoding, shared by the request and configuration ports
   localparam logic [1:0] KIND_CORE  = 2'd0;
   localparam logic [1:0] KIND_GRP_A = 2'd1;
   // values 2 and 3 both map to agent group B

   // index of the lowest set bit, 0 when none is set
   function automatic int unsigned lowest_set(input logic [63:0] vec, input int unsigned n);
      int unsigned idx;
      idx = 0;
      for (int i = 63; i >= 0; i--) begin
         if (i < n && vec[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/way_mask_bank.sv
module way_mask_bank
   import way_victim_sel_pkg::*;
#(
   parameter int WAYS   = 8,
   parameter int CORES  = 4,
   parameter int CORE_W = (CORES > 1) ? $clog2(CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_kind,
   input  logic [CORE_W-1:0] cfg_core,
   input  logic [WAYS-1:0]   cfg_mask,
   input  logic [1:0]        req_kind,
   input  logic [CORE_W-1:0] req_core,
   output logic [WAYS-1:0]   req_mask
);

   logic [CORES-1:0][WAYS-1:0] core_mask_q;
   logic [WAYS-1:0]            grp_a_q;
   logic [WAYS-1:0]            grp_b_q;
   logic                       wr_ok;

   // a mask that forbids every way is refused
   assign wr_ok = cfg_we && !(&cfg_mask);

   for (genvar c = 0; c < CORES; c++) begin : g_core
      always_ff @(posedge clk) begin
         if (!rst_n)
            core_mask_q[c] <= '0;
         else if (wr_ok && cfg_kind == KIND_CORE && int'(cfg_core) == c)
            core_mask_q[c] <= cfg_mask;
      end

      a_r6_core_mask_not_full: assert property (@(posedge clk) disable iff (!rst_n)
         !(&core_mask_q[c]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_a_q <= '0;
         grp_b_q <= '0;
      end else if (wr_ok) begin
         if (cfg_kind == KIND_GRP_A)
            grp_a_q <= cfg_mask;
         else if (cfg_kind[1])
            grp_b_q <= cfg_mask;
      end
   end

   always_comb begin
      req_mask = '0;
      if (req_kind == KIND_CORE) begin
         for (int c = 0; c < CORES; c++)
            if (int'(req_core) == c) req_mask = core_mask_q[c];
      end else if (req_kind == KIND_GRP_A) begin
         req_mask = grp_a_q;
      end else begin
         req_mask = grp_b_q;
      end
   end

   a_r6_reject_keeps_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && &cfg_mask) |=> ($stable(core_mask_q) && $stable(grp_a_q) && $stable(grp_b_q)));

   a_r6_group_masks_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      !(&grp_a_q) && !(&grp_b_q));

endmodule

// File: rtl/way_victim_pick.sv
module way_victim_pick
   import way_victim_sel_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  mask,
   input  logic [WAYS-1:0]  valid,
   input  logic [WAYS-1:0]  dirty,
   input  logic [WAYS-1:0]  locked,
   input  logic [WAYS-1:0]  use_bit,
   output logic             found,
   output logic [WAY_W-1:0] way,
   output logic             victim_dirty,
   output logic [WAYS-1:0]  use_clear
);

   logic [WAYS-1:0] cand;
   logic [WAYS-1:0] cand_inv;
   logic [WAYS-1:0] cand_cold;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign cand[w]      = !mask[w] && !locked[w];
      assign cand_inv[w]  = cand[w] && !valid[w];
      assign cand_cold[w] = cand[w] && !use_bit[w];
   end

   always_comb begin
      logic [63:0] pick_vec;
      int unsigned idx;
      pick_vec = '0;
      use_clear = '0;
      if (|cand_inv)
         pick_vec[WAYS-1:0] = cand_inv;
      else if (|cand_cold)
         pick_vec[WAYS-1:0] = cand_cold;
      else begin
         pick_vec[WAYS-1:0] = cand;
         if (|cand) use_clear = ~locked;
      end
      idx = lowest_set(pick_vec, WAYS);
      found = |cand;
      way = found ? WAY_W'(idx) : '0;
      victim_dirty = found && valid[way] && dirty[way];
   end

endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
   import way_victim_sel_pkg::*;
#(
   parameter int WAYS   = 8,
   parameter int CORES  = 4,
   parameter int WAY_W  = $clog2(WAYS),
   parameter int CORE_W = (CORES > 1) ? $clog2(CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_kind,
   input  logic [CORE_W-1:0] cfg_core,
   input  logic [WAYS-1:0]   cfg_mask,
   input  logic              req_valid,
   input  logic              req_lock,
   input  logic [1:0]        req_kind,
   input  logic [CORE_W-1:0] req_core,
   input  logic [WAYS-1:0]   set_valid,
   input  logic [WAYS-1:0]   set_dirty,
   input  logic [WAYS-1:0]   set_locked,
   input  logic [WAYS-1:0]   set_use,
   output logic              rsp_valid,
   output logic              rsp_found,
   output logic [WAY_W-1:0]  rsp_way,
   output logic              rsp_dirty,
   output logic [WAYS-1:0]   upd_use_clear,
   output logic [WAYS-1:0]   upd_lock_set
);

   if (WAYS < 2 || WAYS > 64) begin : g_bad_ways
      $error("way_victim_sel: WAYS must be within 2..64");
   end
   if (CORES < 1) begin : g_bad_cores
      $error("way_victim_sel: CORES must be at least 1");
   end

   logic [WAYS-1:0]  req_mask;
   logic             pk_found;
   logic [WAY_W-1:0] pk_way;
   logic             pk_dirty;
   logic [WAYS-1:0]  pk_use_clear;

   way_mask_bank #(.WAYS(WAYS), .CORES(CORES), .CORE_W(CORE_W)) u_masks (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_kind (cfg_kind),
      .cfg_core (cfg_core),
      .cfg_mask (cfg_mask),
      .req_kind (req_kind),
      .req_core (req_core),
      .req_mask (req_mask)
   );

   way_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
      .mask         (req_mask),
      .valid        (set_valid),
      .dirty        (set_dirty),
      .locked       (set_locked),
      .use_bit      (set_use),
      .found        (pk_found),
      .way          (pk_way),
      .victim_dirty (pk_dirty),
      .use_clear    (pk_use_clear)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_found     <= 1'b0;
         rsp_way       <= '0;
         rsp_dirty     <= 1'b0;
         upd_use_clear <= '0;
         upd_lock_set  <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_found     <= req_valid && pk_found;
         rsp_way       <= req_valid ? pk_way : '0;
         rsp_dirty     <= req_valid && pk_dirty;
         upd_use_clear <= req_valid ? pk_use_clear : '0;
         upd_lock_set  <= (req_valid && req_lock && pk_found) ? (WAYS'(1) << pk_way) : '0;
      end
   end

   a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r3_never_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !$past(!rst_n)) |=> (!rsp_found || ((set_locked_q >> rsp_way) & 1) == 0));

   a_r9_clear_spares_locked: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ((upd_use_clear & set_locked_q) == '0));

   a_r11_fail_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_found) |-> (upd_use_clear == '0 && upd_lock_set == '0 && !rsp_dirty));

   a_r12_lock_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_lock_set) && (upd_lock_set == '0 || rsp_found));

   // copy of the request's lock bits, used only by the checks above
   logic [WAYS-1:0] set_locked_q;
   always_ff @(posedge clk) begin
      if (!rst_n) set_locked_q <= '0;
      else        set_locked_q <= set_locked;
   end

endmodule

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;

   localparam int WAYS = 8;
   localparam int CORES = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_kind = '0;
   logic [1:0] cfg_core = '0;
   logic [7:0] cfg_mask = '0;
   logic req_valid = 1'b0;
   logic req_lock = 1'b0;
   logic [1:0] req_kind = '0;
   logic [1:0] req_core = '0;
   logic [7:0] set_valid = '0, set_dirty = '0, set_locked = '0, set_use = '0;
   logic rsp_valid, rsp_found, rsp_dirty;
   logic [2:0] rsp_way;
   logic [7:0] upd_use_clear, upd_lock_set;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   way_victim_sel #(.WAYS(WAYS), .CORES(CORES)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_core(cfg_core), .cfg_mask(cfg_mask),
      .req_valid(req_valid), .req_lock(req_lock), .req_kind(req_kind), .req_core(req_core),
      .set_valid(set_valid), .set_dirty(set_dirty), .set_locked(set_locked), .set_use(set_use),
      .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
      .upd_use_clear(upd_use_clear), .upd_lock_set(upd_lock_set)
   );

   // {valid, dirty, locked, use, lock_req, found, way, dirty_out, use_clear, lock_set}
   localparam int NV = 8;
   localparam logic [53:0] VEC [NV] = '{
      {8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00}, // R8 all cold
      {8'hF7, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 3'd3, 1'b0, 8'h00, 8'h00}, // R7 R10 invalid dirty
      {8'hFF, 8'h20, 8'h00, 8'hDF, 1'b0, 1'b1, 3'd5, 1'b1, 8'h00, 8'h00}, // R8 R10
      {8'hFF, 8'h01, 8'h03, 8'hFF, 1'b0, 1'b1, 3'd2, 1'b0, 8'hFC, 8'h00}, // R9 R3
      {8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00}, // R11 R12 all locked
      {8'hFF, 8'h10, 8'h0F, 8'hF0, 1'b1, 1'b1, 3'd4, 1'b1, 8'hF0, 8'h10}, // R9 R12
      {8'hFE, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1, 3'd1, 1'b0, 8'h00, 8'h02}, // R3 R7 locked invalid
      {8'h7F, 8'h80, 8'h80, 8'hFF, 1'b0, 1'b1, 3'd0, 1'b0, 8'h7F, 8'h00}  // R3 R9
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic write_mask(input logic [1:0] kind, input logic [1:0] core, input logic [7:0] m);
      cfg_we = 1'b1; cfg_kind = kind; cfg_core = core; cfg_mask = m;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic request(input logic [1:0] kind, input logic [1:0] core, input logic lk,
                          input logic [7:0] v, input logic [7:0] d,
                          input logic [7:0] l, input logic [7:0] u);
      req_valid = 1'b1; req_lock = lk; req_kind = kind; req_core = core;
      set_valid = v; set_dirty = d; set_locked = l; set_use = u;
      @(negedge clk);
      req_valid = 1'b0; req_lock = 1'b0;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", "rsp_valid after reset", rsp_valid, 0);
      check("R11", "found after reset", rsp_found, 0);

      // R2: default masks allow every way
      request(2'd0, 2'd1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R1", "rsp_valid", rsp_valid, 1);
      check("R2", "way core1", rsp_way, 0);
      request(2'd2, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R2", "found group B", rsp_found, 1);
      @(negedge clk);
      check("R1", "rsp_valid idle", rsp_valid, 0);

      for (int i = 0; i < NV; i++) begin
         logic [53:0] e;
         e = VEC[i];
         request(2'd0, 2'd0, e[21], e[53:46], e[45:38], e[37:30], e[29:22]);
         check("R7-vector", "found", rsp_found, e[20]);
         check("R8-vector", "way", rsp_way, e[19:17]);
         check("R10", "dirty", rsp_dirty, e[16]);
         check("R9", "use_clear", upd_use_clear, e[15:8]);
         check("R12", "lock_set", upd_lock_set, e[7:0]);
      end

      // R4: core0 mask forbids ways 0..3, core1 untouched
      write_mask(2'd0, 2'd0, 8'h0F);
      request(2'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R4", "core0 way", rsp_way, 4);
      request(2'd0, 2'd1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R4", "core1 way", rsp_way, 0);

      // R5: group masks independent
      write_mask(2'd1, 2'd0, 8'h7F);
      request(2'd1, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R5", "group A way", rsp_way, 7);
      request(2'd3, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R5", "group B way", rsp_way, 0);
      write_mask(2'd2, 2'd0, 8'h3F);
      request(2'd2, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R5", "group B masked way", rsp_way, 6);
      request(2'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R5", "core0 unaffected", rsp_way, 4);

      // R6: all-ones write rejected
      write_mask(2'd0, 2'd0, 8'hFF);
      request(2'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R6", "core0 found", rsp_found, 1);
      check("R6", "core0 old mask way", rsp_way, 4);
      write_mask(2'd1, 2'd0, 8'hFF);
      request(2'd1, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R6", "group A old mask way", rsp_way, 7);

      // R11 R12: lock with no permitted unlocked way leaves state alone
      request(2'd0, 2'd0, 1'b1, 8'hFF, 8'hFF, 8'hF0, 8'hFF);
      check("R11", "lock fail found", rsp_found, 0);
      check("R11", "lock fail way", rsp_way, 0);
      check("R11", "lock fail dirty", rsp_dirty, 0);
      check("R11", "lock fail use_clear", upd_use_clear, 0);
      check("R12", "lock fail lock_set", upd_lock_set, 0);

      // R3 with mask: only way 6 remains for core0
      request(2'd0, 2'd0, 1'b1, 8'hFF, 8'h40, 8'hB0, 8'hFF);
      check("R3", "masked locked way", rsp_way, 6);
      check("R10", "masked dirty", rsp_dirty, 1);
      check("R9", "masked use_clear", upd_use_clear, 8'h4F);
      check("R12", "masked lock_set", upd_lock_set, 8'h40);

      // reset returns masks to zero
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      request(2'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
      check("R2", "core0 after reset", rsp_way, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule